// File: doc/BRIEF.md
# Transmit Write Steering with Critical-Address Promotion

This block sits in front of a node's two transmit queues and decides, in the same cycle a shared write is presented, which queue it enters. It uses two queues: a priority queue for short messages and a bulk queue for long block transfers. Each write carries an address, a data word, a two-bit class and a flag from the window lookup that says whether the target window is open. A write to a closed window is taken from the source and discarded. A short write known to be independent always goes to the priority queue. A long block write always goes to the bulk queue. A short write tagged as conditional goes to the bulk queue unless its address is present in a small associative store of critical addresses. In that case it is promoted to the priority queue.

Run-time code fills the store with an insert command and empties it with a delete command. Both use one shared address input. The address compare runs in parallel with the write's routing, so promotion adds no cycle. Routing happens before either queue is written. The source side uses a valid/ready handshake. When the queue a write is headed for reports full, ready drops and the source holds the write until space frees up.

Top module: `tx_steer`

## Requirements
- R1: After reset the critical-address store is empty and the overflow flag is 0. With no valid write presented, neither queue write strobe is asserted.
- R2: A write of class 2'b00 (short, independent) to an open window is written to the priority queue in the same cycle. The priority queue address and data equal the input address and data.
- R3: A write of class 2'b01 (long block) to an open window is written to the bulk queue in the same cycle.
- R4: A write of class 2'b10 (short, conditional) to an open window goes to the priority queue when its address matches a valid store entry, and to the bulk queue otherwise. Class 2'b11 is treated like class 2'b01.
- R5: A write whose window flag is 0 strobes neither queue, and ready stays 1 so that the write is consumed.
- R6: When the queue a write is routed to reports full, ready is 0 and neither queue is strobed. A full flag on the other queue has no effect on that write.
- R7: An insert command makes its address match in later cycles. A delete command removes the entry holding its address, so that later conditional writes to that address go to the bulk queue.
- R8: Inserting an address that is already present creates no second entry, so one delete is enough to remove it.
- R9: The store holds NENT entries (8 by default). An insert of a new address into a full store is dropped and sets a sticky overflow flag. Only reset clears that flag.
- R10: Promoting a conditional write does not remove its store entry.
- R11: A lookup in the same cycle as an insert or delete of the same address sees the store contents from before that update.
- R12: When insert and delete are asserted together, the delete takes effect and the insert is ignored.
- R13: At most one queue write strobe is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write presented by the source |
| in_ready | output | 1 | Write accepted this cycle when valid |
| in_addr | input | AW | Write address |
| in_data | input | DW | Write data |
| in_class | input | 2 | 00 short independent, 01 long block, 10 short conditional, 11 as 01 |
| in_win_open | input | 1 | Window lookup result: 1 means forward |
| cmd_ins | input | 1 | Insert cmd_addr into the store |
| cmd_del | input | 1 | Delete cmd_addr from the store |
| cmd_addr | input | AW | Address for insert or delete |
| pq_wr | output | 1 | Priority queue write strobe |
| pq_full | input | 1 | Priority queue full |
| pq_addr | output | AW | Priority queue write address |
| pq_data | output | DW | Priority queue write data |
| bq_wr | output | 1 | Bulk queue write strobe |
| bq_full | input | 1 | Bulk queue full |
| bq_addr | output | AW | Bulk queue write address |
| bq_data | output | DW | Bulk queue write data |
| ins_overflow | output | 1 | Sticky flag: an insert was dropped because the store was full |

## Verification
The properties assume three things about the inputs. The class and window flag are valid whenever in_valid is high. The queue full flags are synchronous to the clock. The insert and delete commands change only between clock edges. The bench drives every input just after the falling edge and samples the strobes and ready one nanosecond later, which keeps all of these assumptions true. The bench observes the store only through the routing of conditional writes and through the overflow flag, so every store update is checked at the ports in the cycle after it happens.

// File: rtl/tx_steer.sv
module tx_steer #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NENT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [1:0]    in_class,
  input  logic          in_win_open,
  input  logic          cmd_ins,
  input  logic          cmd_del,
  input  logic [AW-1:0] cmd_addr,
  output logic          pq_wr,
  input  logic          pq_full,
  output logic [AW-1:0] pq_addr,
  output logic [DW-1:0] pq_data,
  output logic          bq_wr,
  input  logic          bq_full,
  output logic [AW-1:0] bq_addr,
  output logic [DW-1:0] bq_data,
  output logic          ins_overflow
);

  localparam logic [1:0] CLS_IND  = 2'b00;
  localparam logic [1:0] CLS_COND = 2'b10;

  logic [NENT-1:0] vld;
  logic [AW-1:0]   tag [NENT];
  logic [NENT-1:0] look_hit, cmd_hit, free_oh;
  logic            is_pri, sel_full, fwd, do_ins;

  for (genvar g = 0; g < NENT; g++) begin : g_cam
    assign look_hit[g] = vld[g] && (tag[g] == in_addr);
    assign cmd_hit[g]  = vld[g] && (tag[g] == cmd_addr);
  end

  assign free_oh = ~vld & (vld + NENT'(1));
  assign do_ins  = cmd_ins && !cmd_del && !(|cmd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld          <= '0;
      ins_overflow <= 1'b0;
    end else if (cmd_del) begin
      vld <= vld & ~cmd_hit;
    end else if (do_ins) begin
      if (|free_oh) vld <= vld | free_oh;
      else          ins_overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++)
      if (do_ins && free_oh[i]) tag[i] <= cmd_addr;
  end

  assign is_pri   = (in_class == CLS_IND) || ((in_class == CLS_COND) && (|look_hit));
  assign sel_full = is_pri ? pq_full : bq_full;
  assign in_ready = !in_win_open || !sel_full;
  assign fwd      = in_valid && in_win_open && !sel_full;

  assign pq_wr   = fwd && is_pri;
  assign bq_wr   = fwd && !is_pri;
  assign pq_addr = in_addr;
  assign pq_data = in_data;
  assign bq_addr = in_addr;
  assign bq_data = in_data;

endmodule

// File: rtl/tx_steer_chk.sv
module tx_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [1:0] in_class,
  input logic       in_win_open,
  input logic       pq_wr,
  input logic       pq_full,
  input logic       bq_wr,
  input logic       bq_full,
  input logic       ins_overflow
);

  p_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(pq_wr && bq_wr));

  p_pq_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pq_wr |-> !pq_full);

  p_bq_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bq_wr |-> !bq_full);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_win_open && !in_ready) |-> (!pq_wr && !bq_wr));

  p_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_win_open) |-> (!pq_wr && !bq_wr && in_ready));

  p_indep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_win_open && in_class == 2'b00 && !pq_full) |-> pq_wr);

  p_long_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_win_open && in_class == 2'b01 && !bq_full) |-> bq_wr);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!pq_wr && !bq_wr));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_overflow |=> ins_overflow);

endmodule

bind tx_steer tx_steer_chk u_chk (.*);

// File: tb/sim_tx_steer.sv
`timescale 1ns/1ps
module sim_tx_steer;
  localparam int AW = 32, DW = 32, NENT = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_win_open = 0, cmd_ins = 0, cmd_del = 0;
  logic pq_full = 0, bq_full = 0;
  logic [AW-1:0] in_addr = '0, cmd_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [1:0] in_class = '0;
  logic in_ready, pq_wr, bq_wr, ins_overflow;
  logic [AW-1:0] pq_addr, bq_addr;
  logic [DW-1:0] pq_data, bq_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_steer #(.AW(AW), .DW(DW), .NENT(NENT)) u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic route(input logic [31:0] a, input logic [1:0] c, input bit w,
                       input bit pf, input bit bf, input bit ep, input bit eb,
                       input bit er, input string req);
    in_valid = 1; in_addr = a; in_data = a ^ 32'h5a5a_0000; in_class = c;
    in_win_open = w; pq_full = pf; bq_full = bf;
    #1;
    chk(pq_wr, ep, {req, " pq_wr"});
    chk(bq_wr, eb, {req, " bq_wr"});
    chk(in_ready, er, {req, " ready"});
    chk(pq_wr && bq_wr, 0, "R13 exclusive");
    in_valid = 0; pq_full = 0; bq_full = 0;
  endtask

  task automatic op(input bit ins, input bit del, input logic [31:0] a);
    @(negedge clk); cmd_ins = ins; cmd_del = del; cmd_addr = a;
    @(posedge clk); #1; cmd_ins = 0; cmd_del = 0;
  endtask

  task automatic t_reset();
    chk(ins_overflow, 0, "R1 overflow");
    chk(pq_wr || bq_wr, 0, "R1 idle strobes");
    @(negedge clk); route(32'h0, 2'b10, 1, 0, 0, 0, 1, 1, "R1 empty store");
  endtask

  task automatic t_classes();
    @(negedge clk); route(32'h100, 2'b00, 1, 0, 0, 1, 0, 1, "R2");
    @(negedge clk); in_valid = 1; in_addr = 32'h1234; in_data = 32'hcafe; in_class = 2'b00;
    in_win_open = 1; #1;
    chk(pq_addr, 32'h1234, "R2 addr"); chk(pq_data, 32'hcafe, "R2 data");
    in_valid = 0;
    @(negedge clk); route(32'h200, 2'b01, 1, 0, 0, 0, 1, 1, "R3");
    @(negedge clk); route(32'h300, 2'b10, 1, 0, 0, 0, 1, 1, "R4 miss");
    @(negedge clk); route(32'h300, 2'b11, 1, 0, 0, 0, 1, 1, "R4 class3");
  endtask

  task automatic t_closed();
    @(negedge clk); route(32'h100, 2'b00, 0, 0, 0, 0, 0, 1, "R5 short");
    @(negedge clk); route(32'h200, 2'b01, 0, 1, 1, 0, 0, 1, "R5 long");
  endtask

  task automatic t_backpressure();
    @(negedge clk); route(32'h100, 2'b00, 1, 1, 0, 0, 0, 0, "R6 pq full");
    @(negedge clk); route(32'h100, 2'b00, 1, 0, 1, 1, 0, 1, "R6 other full");
    @(negedge clk); route(32'h200, 2'b01, 1, 0, 1, 0, 0, 0, "R6 bq full");
    @(negedge clk); route(32'h200, 2'b01, 1, 1, 0, 0, 1, 1, "R6 pq full ignored");
  endtask

  task automatic t_ins_del();
    op(1, 0, 32'hA0);
    @(negedge clk); route(32'hA0, 2'b10, 1, 0, 0, 1, 0, 1, "R7 hit");
    @(negedge clk); route(32'hA0, 2'b10, 1, 0, 0, 1, 0, 1, "R10 kept");
    @(negedge clk); route(32'hA4, 2'b10, 1, 0, 0, 0, 1, 1, "R7 other addr");
    op(0, 1, 32'hA0);
    @(negedge clk); route(32'hA0, 2'b10, 1, 0, 0, 0, 1, 1, "R7 deleted");
  endtask

  task automatic t_dup();
    op(1, 0, 32'hB0); op(1, 0, 32'hB0);
    op(0, 1, 32'hB0);
    @(negedge clk); route(32'hB0, 2'b10, 1, 0, 0, 0, 1, 1, "R8 single delete");
  endtask

  task automatic t_same_cycle();
    @(negedge clk); cmd_ins = 1; cmd_addr = 32'hC0;
    route(32'hC0, 2'b10, 1, 0, 0, 0, 1, 1, "R11 ins old");
    @(posedge clk); #1; cmd_ins = 0;
    @(negedge clk); route(32'hC0, 2'b10, 1, 0, 0, 1, 0, 1, "R11 ins new");
    @(negedge clk); cmd_del = 1; cmd_addr = 32'hC0;
    route(32'hC0, 2'b10, 1, 0, 0, 1, 0, 1, "R11 del old");
    @(posedge clk); #1; cmd_del = 0;
    @(negedge clk); route(32'hC0, 2'b10, 1, 0, 0, 0, 1, 1, "R11 del new");
  endtask

  task automatic t_both();
    op(1, 1, 32'hD0);
    @(negedge clk); route(32'hD0, 2'b10, 1, 0, 0, 0, 1, 1, "R12 absent");
    op(1, 0, 32'hD0);
    op(1, 1, 32'hD0);
    @(negedge clk); route(32'hD0, 2'b10, 1, 0, 0, 0, 1, 1, "R12 present");
  endtask

  task automatic t_overflow();
    for (int i = 0; i < NENT; i++) op(1, 0, 32'hE00 + i);
    chk(ins_overflow, 0, "R9 fill no ovf");
    for (int i = 0; i < NENT; i++) begin
      @(negedge clk); route(32'hE00 + i, 2'b10, 1, 0, 0, 1, 0, 1, "R9 filled hit");
    end
    op(1, 0, 32'hEFF);
    chk(ins_overflow, 1, "R9 ovf set");
    @(negedge clk); route(32'hEFF, 2'b10, 1, 0, 0, 0, 1, 1, "R9 dropped");
    op(0, 1, 32'hE03);
    op(1, 0, 32'hEFF);
    chk(ins_overflow, 1, "R9 sticky");
    @(negedge clk); route(32'hEFF, 2'b10, 1, 0, 0, 1, 0, 1, "R9 freed slot");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset_pre: begin
      chk(ins_overflow, 0, "R1 in reset");
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_classes();
    t_closed();
    t_backpressure();
    t_ins_del();
    t_dup();
    t_same_cycle();
    t_both();
    t_overflow();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule